// File: doc/BRIEF.md
# Group Blink Generator with Sync

This block produces a single blink gate shared by a group of outputs. The gate repeats with a programmable period and on-fraction. A clock-enable tick advances a time base. Each blink period has 256 steps, and every step lasts `freq_code + 1` ticks. With the tick running at 6144 Hz, the blink frequency is therefore 24/(`freq_code`+1) Hz. The gate is high during the first `duty_code` steps of each period, which gives an on-fraction of `duty_code`/256.

The frequency and duty codes pass through a two-level path. A `commit` strobe captures the input codes into a pending set. The pending set becomes active only at the start of the next period, so a running period is never shortened or stretched.

A two-bit mode selects how several generators stay aligned:
- In master mode the block drives a square wave on the sync pin. The wave is high for the first half of every period.
- In slave mode the pin is an input. Each rising edge of the synchronised input restarts the period.
- In the remaining modes the pin is driven low.

Top module: `blink_gen`

## Requirements
- R1: After reset, `blink_o` is 0, the step position is 0, and both the pending and the active codes are 0. The first period is therefore 256 ticks long and has a gate that stays low.
- R2: A period is exactly 256 × (F+1) ticks long, where F is the active frequency code. Each step lasts F+1 ticks.
- R3: Step index s counts from 0 to 255 within a period. `blink_o` is 1 exactly when s is less than the active duty code D.
- R4: A cycle with `commit`=1 stores `freq_code` and `duty_code` as pending values. The pending values become active only when a new period starts. A `commit` in the same cycle as a period start takes effect for the period that is starting.
- R5: When `sync_mode` = 2'b10, `sync_oe` is 1 and `sync_o` is 1 exactly when the step index is below 128.
- R6: When `sync_mode` = 2'b11:
  - `sync_oe` is 0 and `sync_o` is 0.
  - A rising edge of `sync_in` passes through a two-flop synchroniser. On the third clock edge after the rise, the step position is forced to 0 and the pending codes are loaded. This restart takes precedence over a tick in the same cycle.
- R7: When `sync_mode` is 2'b00 or 2'b01, `sync_oe` is 1, `sync_o` is 0, and `sync_in` has no effect on the gate.
- R8: While `tick` is 0 and no slave restart occurs, the position holds and `blink_o` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Time-base enable; advances the position by one tick |
| commit | input | 1 | Captures the frequency and duty codes as pending values |
| freq_code | input | FREQ_W (8) | Frequency code F; each step lasts F+1 ticks |
| duty_code | input | STEP_W (8) | Duty code D; the gate is high for the first D steps |
| sync_mode | input | 2 | 10 = master, 11 = slave, 00/01 = pin held low |
| sync_in | input | 1 | Sync pin input value (asynchronous) |
| blink_o | output | 1 | Group blink gate |
| sync_o | output | 1 | Sync pin drive value |
| sync_oe | output | 1 | Sync pin output enable |

## Verification
Two pairs of events can coincide, and the bench provokes each pair on purpose.

The first pair is a `commit` pulse and a period wrap. The bench raises `commit` on the very tick that ends the first period, with new frequency and duty codes. The following period must show the new step length and duty at once, not one period later.

The second pair is a slave restart and a running tick. The restart edge of the synchronised input lands while `tick` is high. The gate must return to step 0, which is high for a duty of 128, rather than advancing to step 147, which would be low.

// File: rtl/blink_gen.sv
module blink_gen #(
  parameter int FREQ_W  = 8,
  parameter int STEP_W  = 8,
  parameter int SYNC_FF = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              commit,
  input  logic [FREQ_W-1:0] freq_code,
  input  logic [STEP_W-1:0] duty_code,
  input  logic [1:0]        sync_mode,
  input  logic              sync_in,
  output logic              blink_o,
  output logic              sync_o,
  output logic              sync_oe
);
  localparam logic [STEP_W-1:0] STEP_LAST = '1;

  logic [SYNC_FF:0]   sync_sh;
  logic [FREQ_W-1:0]  pend_f, act_f, pre_q;
  logic [STEP_W-1:0]  pend_d, act_d, step_q;
  logic               master, slave, rise, restart, step_end, wrap;

  assign master   = (sync_mode == 2'b10);
  assign slave    = (sync_mode == 2'b11);
  assign rise     = sync_sh[SYNC_FF-1] & ~sync_sh[SYNC_FF];
  assign restart  = slave & rise;
  assign step_end = tick && (pre_q == act_f);
  assign wrap     = step_end && (step_q == STEP_LAST);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_sh <= '0;
    else        sync_sh <= {sync_sh[SYNC_FF-1:0], sync_in};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pend_f <= '0;
      pend_d <= '0;
    end else if (commit) begin
      pend_f <= freq_code;
      pend_d <= duty_code;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      act_f  <= '0;
      act_d  <= '0;
      pre_q  <= '0;
      step_q <= '0;
    end else if (restart || wrap) begin
      act_f  <= commit ? freq_code : pend_f;
      act_d  <= commit ? duty_code : pend_d;
      pre_q  <= '0;
      step_q <= '0;
    end else if (step_end) begin
      pre_q  <= '0;
      step_q <= step_q + 1'b1;
    end else if (tick) begin
      pre_q  <= pre_q + 1'b1;
    end

  assign blink_o = (step_q < act_d);
  assign sync_o  = master & ~step_q[STEP_W-1];
  assign sync_oe = ~slave;
endmodule

// File: rtl/blink_gen_chk.sv
module blink_gen_chk #(
  parameter int FREQ_W = 8,
  parameter int STEP_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic [1:0]        sync_mode,
  input logic              sync_o,
  input logic              sync_oe,
  input logic              restart,
  input logic              wrap,
  input logic [FREQ_W-1:0] pre_q,
  input logic [FREQ_W-1:0] act_f,
  input logic [STEP_W-1:0] step_q,
  input logic [STEP_W-1:0] act_d
);
  localparam int HALF = 1 << (STEP_W - 1);

  AST_SLAVE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    sync_mode == 2'b11 |-> !sync_oe && !sync_o); // R6
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_mode[1] |-> sync_oe && !sync_o); // R7
  AST_MASTER_WAVE: assert property (@(posedge clk) disable iff (!rst_n)
    sync_mode == 2'b10 |-> sync_oe && (sync_o == (int'(step_q) < HALF))); // R5
  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> step_q == '0 && pre_q == '0); // R6
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !restart |=> $stable(step_q) && $stable(pre_q)); // R8
  AST_ACTIVE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap && !restart |=> $stable(act_d) && $stable(act_f)); // R4
  AST_PRESCALE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    pre_q <= act_f); // R2
endmodule

bind blink_gen blink_gen_chk #(.FREQ_W(FREQ_W), .STEP_W(STEP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .sync_mode(sync_mode),
  .sync_o(sync_o), .sync_oe(sync_oe), .restart(restart), .wrap(wrap),
  .pre_q(pre_q), .act_f(act_f), .step_q(step_q), .act_d(act_d)
);

// File: tb/tb_blink_gen.sv
module tb_blink_gen;
  logic clk = 0, rst_n = 0, tick = 0, commit = 0, sync_in = 0;
  logic [7:0] freq_code = 0, duty_code = 0;
  logic [1:0] sync_mode = 0;
  logic blink_o, sync_o, sync_oe;
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  blink_gen dut (.clk(clk), .rst_n(rst_n), .tick(tick), .commit(commit),
    .freq_code(freq_code), .duty_code(duty_code), .sync_mode(sync_mode),
    .sync_in(sync_in), .blink_o(blink_o), .sync_o(sync_o), .sync_oe(sync_oe));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset(input logic [1:0] mode);
    rst_n = 0; tick = 0; commit = 0; sync_in = 0; sync_mode = mode;
    freq_code = 0; duty_code = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(blink_o == 0, "R1 gate after reset", blink_o, 0);
    chk(sync_oe == (mode != 2'b11), "R1 oe after reset", sync_oe, mode != 2'b11);
  endtask

  function automatic int step_of(int pos, int f);
    return (pos % (256 * (f + 1))) / (f + 1);
  endfunction

  initial begin
    #(150000 * 20);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int fl[3] = '{0, 1, 3};
    int dl[5] = '{0, 1, 127, 128, 255};
    // R2 R3 R5 sweep in master mode
    foreach (fl[fi]) foreach (dl[di]) begin
      int f = fl[fi], d = dl[di], p = 256 * (fl[fi] + 1);
      do_reset(2'b10);
      freq_code = 8'(f); duty_code = 8'(d); commit = 1;
      @(negedge clk);
      commit = 0; tick = 1;
      for (int k = 0; k < 256 + 2 * p; k++) begin
        int s, eg;
        if (k < 256) begin s = k; eg = 0; end
        else begin s = step_of(k - 256, f); eg = (s < d); end
        chk(blink_o == eg, "R2/R3 gate", blink_o, eg);
        chk(sync_o == (s < 128) && sync_oe, "R5 master wave", sync_o, s < 128);
        @(negedge clk);
      end
    end

    // R4 deferred commit, R8 hold, R7 ignore sync_in, mode 00
    do_reset(2'b00);
    duty_code = 64; commit = 1;
    @(negedge clk);
    commit = 0; tick = 1;
    for (int k = 0; k < 1024; k++) begin
      int eg;
      eg = (k < 256) ? 0 : (k < 512) ? int'((k - 256) < 64) : int'(((k - 512) % 256) < 200);
      chk(blink_o == eg, "R4 deferred commit", blink_o, eg);
      chk(sync_o == 0 && sync_oe == 1, "R7 pin low", sync_o, 0);
      if (k == 300) begin
        tick = 0;
        repeat (20) begin
          @(negedge clk);
          chk(blink_o == eg, "R8 hold without tick", blink_o, eg);
        end
        tick = 1;
      end
      if (k == 600 || k == 720) sync_in = 1;
      if (k == 700) sync_in = 0;
      if (k == 356) begin duty_code = 200; commit = 1; end
      @(negedge clk);
      commit = 0;
    end

    do_reset(2'b01);
    sync_in = 1;
    repeat (4) @(negedge clk);
    chk(sync_o == 0 && sync_oe == 1, "R7 mode 01 pin low", sync_o, 0);

    // R4 commit on the wrap tick
    do_reset(2'b10);
    tick = 1;
    for (int k = 0; k < 256 + 1024; k++) begin
      int s, eg;
      if (k < 256) begin s = k; eg = 0; end
      else begin s = step_of(k - 256, 1); eg = (s < 100); end
      chk(blink_o == eg, "R4 commit at period start", blink_o, eg);
      chk(sync_o == (s < 128), "R5 wave after commit", sync_o, s < 128);
      if (k == 255) begin freq_code = 1; duty_code = 100; commit = 1; end
      @(negedge clk);
      commit = 0;
    end

    // R6 slave restart beats tick
    do_reset(2'b11);
    duty_code = 128; commit = 1;
    @(negedge clk);
    commit = 0; tick = 1;
    for (int k = 0; k < 400; k++) begin
      int eg;
      eg = (k < 256) ? 0 : int'((k - 256) < 128);
      chk(blink_o == eg, "R6 slave free run", blink_o, eg);
      chk(sync_oe == 0 && sync_o == 0, "R6 pin released", sync_oe, 0);
      @(negedge clk);
    end
    sync_in = 1;
    repeat (2) @(negedge clk);
    chk(blink_o == 0, "R6 before restart", blink_o, 0);
    @(negedge clk);
    chk(blink_o == 1, "R6 restart to step 0", blink_o, 1);
    for (int j = 1; j < 300; j++) begin
      @(negedge clk);
      chk(blink_o == ((j % 256) < 128), "R6 after restart", blink_o, (j % 256) < 128);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule